// File: doc/BRIEF.md
# Three-Stage Pipeline Fetch and Flush Controller

This block steers instruction flow through a fetch, decode and execute pipeline for a 32-bit, fixed-length instruction set. It puts a word-aligned fetch address out to instruction memory and takes the returned word in the same cycle. It carries the word and its address down through decode and execute, each stage with its own valid flag. The execute stage is given the program-counter value it reads, which is its own address plus 8.

Execute can ask for a taken branch or a direct program-counter write. Either request flushes the two younger stages and restarts fetch at the new target. An interrupt request lets the instruction now in execute retire and discards the ones behind it. Fetch then restarts at a vector address given on a port, and a one-cycle acknowledge comes out with the return address.

There is no branch prediction, and fetch runs sequentially until a redirect. A stall input freezes the whole pipeline.

Top module: `pipe_flow_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `exValid` and `irqAck` are 0 and `fetchAddr` is 0. The first instruction to reach execute is the one at address 0.
- R2: `fetchAddr` always has bits [1:0] at zero. Any target or vector address is forced to a word boundary by clearing its two low bits.
- R3: Whenever `exValid` is 1, `exPcRead` equals `exAddr + 8`, and it also equals the current `fetchAddr`.
- R4: When `branchTaken` or `pcWrite` is accepted (stall low), `fetchAddr` holds the target on the next cycle. `exValid` is then 0 for the next two advancing cycles. If both requests arrive together, `branchTarget` wins over `pcWriteData`.
- R5: In an advancing cycle with a valid instruction in execute and no redirect request, `fetchAddr` increases by exactly 4 on the next cycle.
- R6: When `irqReq` is accepted (stall low), the instruction in execute retires and the younger instructions are discarded. On the next cycle `fetchAddr` equals the vector and `irqAck` is 1 for one cycle. `retAddr` then holds the address of the first discarded instruction, which is the next sequential address after the retiring one.
- R7: While `stall` is 1, no instruction retires and no request is accepted. On the next cycle `fetchAddr`, `exValid` and `exAddr` are unchanged and `irqAck` is 0.
- R8: If a branch and an interrupt are accepted in the same cycle, fetch goes to the interrupt vector and `retAddr` is the aligned branch target.
- R9: The sequence of retired addresses follows program order, and each retired `exInstr` is the word that memory returned for `exAddr`. An instruction retires in a cycle where `exValid` is 1 and `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all stages and the fetch address |
| fetchAddr | output | 32 | Word-aligned address sent to instruction memory |
| fetchInstr | input | 32 | Instruction word returned for `fetchAddr` in the same cycle |
| branchTaken | input | 1 | Execute requests a taken branch |
| branchTarget | input | 32 | Branch destination |
| pcWrite | input | 1 | Execute writes the program counter directly |
| pcWriteData | input | 32 | Value written to the program counter |
| irqReq | input | 1 | Interrupt request |
| irqVector | input | 32 | Handler vector address |
| exValid | output | 1 | Execute stage holds a valid instruction |
| exAddr | output | 32 | Address of the instruction in execute |
| exInstr | output | 32 | Instruction word in execute |
| exPcRead | output | 32 | Program-counter value read by execute |
| irqAck | output | 1 | One-cycle pulse after an interrupt is accepted |
| retAddr | output | 32 | Return address for the handler, valid with `irqAck` |

## Verification
Each output is a register or is decoded from registers, so every result is due one clock edge after the cycle in which its request was presented. The two flush bubbles show up on the first and second samples that follow the redirect edge, counting only edges with stall low. The bench samples one time unit after each rising edge and only then drives that cycle's inputs. It compares each result against the values it noted for the cycle before. It acts as the execute stage, raising requests from the address it sees in execute. It keeps its own program-order reference for the retired addresses.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {TGT_SEQ, TGT_BRANCH, TGT_PCWR, TGT_VEC} tgtSel_e;
  typedef enum logic [1:0] {RET_DEC, RET_FETCH, RET_BRANCH, RET_PCWR} retSel_e;

  typedef struct packed {
    logic    advance;
    logic    redirect;
    logic    irqTake;
    tgtSel_e tgtSel;
    retSel_e retSel;
  } pipeCtl_t;
endpackage

// File: rtl/pfc_control.sv
module pfc_control
  import pfc_pkg::*;
(
  input  logic     stall,
  input  logic     branchTaken,
  input  logic     pcWrite,
  input  logic     irqReq,
  input  logic     decValid,
  output pipeCtl_t ctl
);
  always_comb begin
    ctl.advance  = ~stall;
    ctl.redirect = ~stall & (irqReq | branchTaken | pcWrite);
    ctl.irqTake  = ~stall & irqReq;

    if (irqReq)           ctl.tgtSel = TGT_VEC;
    else if (branchTaken) ctl.tgtSel = TGT_BRANCH;
    else if (pcWrite)     ctl.tgtSel = TGT_PCWR;
    else                  ctl.tgtSel = TGT_SEQ;

    if (branchTaken)   ctl.retSel = RET_BRANCH;
    else if (pcWrite)  ctl.retSel = RET_PCWR;
    else if (decValid) ctl.retSel = RET_DEC;
    else               ctl.retSel = RET_FETCH;
  end
endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pipeCtl_t      ctl,
  input  logic [AW-1:0] branchTarget,
  input  logic [AW-1:0] pcWriteData,
  input  logic [AW-1:0] irqVector,
  input  logic [IW-1:0] fetchInstr,
  output logic [AW-1:0] fetchAddr,
  output logic          decValid,
  output logic          exValid,
  output logic [AW-1:0] exAddr,
  output logic [IW-1:0] exInstr,
  output logic [AW-1:0] exPcRead,
  output logic          irqAck,
  output logic [AW-1:0] retAddr
);
  localparam int            STEP  = IW / 8;
  localparam int            PCOFS = 2 * STEP;
  localparam int            NST   = 2;          // decode, execute
  localparam int            EX    = NST - 1;
  localparam logic [AW-1:0] AMASK = ~(AW'(STEP) - AW'(1));

  logic          fetchVld;
  logic [AW-1:0] fetchPc;
  logic [AW-1:0] nextTarget;
  logic [AW-1:0] retSrc;
  logic          ackQ;
  logic [AW-1:0] retQ;

  always_comb begin
    case (ctl.tgtSel)
      TGT_BRANCH: nextTarget = branchTarget;
      TGT_PCWR:   nextTarget = pcWriteData;
      TGT_VEC:    nextTarget = irqVector;
      default:    nextTarget = fetchPc + AW'(STEP);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetchVld <= 1'b0;
      fetchPc  <= '0;
    end else if (ctl.advance) begin
      fetchVld <= 1'b1;
      if (ctl.redirect)  fetchPc <= nextTarget & AMASK;
      else if (fetchVld) fetchPc <= fetchPc + AW'(STEP);
    end
  end

  genvar gi;
  for (gi = 0; gi < NST; gi++) begin : gStage
    logic          inVld;
    logic [AW-1:0] inPc;
    logic [IW-1:0] inWord;
    logic          vld;
    logic [AW-1:0] pc;
    logic [IW-1:0] word;

    if (gi == 0) begin : gSrcFetch
      assign inVld  = fetchVld;
      assign inPc   = fetchPc;
      assign inWord = fetchInstr;
    end else begin : gSrcPrev
      assign inVld  = gStage[gi-1].vld;
      assign inPc   = gStage[gi-1].pc;
      assign inWord = gStage[gi-1].word;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld  <= 1'b0;
        pc   <= '0;
        word <= '0;
      end else if (ctl.advance) begin
        vld  <= ctl.redirect ? 1'b0 : inVld;
        pc   <= inPc;
        word <= inWord;
      end
    end
  end

  always_comb begin
    case (ctl.retSel)
      RET_BRANCH: retSrc = branchTarget;
      RET_PCWR:   retSrc = pcWriteData;
      RET_DEC:    retSrc = gStage[0].pc;
      default:    retSrc = fetchPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackQ <= 1'b0;
      retQ <= '0;
    end else begin
      ackQ <= ctl.irqTake;
      if (ctl.irqTake) retQ <= retSrc & AMASK;
    end
  end

  assign fetchAddr = fetchPc;
  assign decValid  = gStage[0].vld;
  assign exValid   = gStage[EX].vld;
  assign exAddr    = gStage[EX].pc;
  assign exInstr   = gStage[EX].word;
  assign exPcRead  = gStage[EX].pc + AW'(PCOFS);
  assign irqAck    = ackQ;
  assign retAddr   = retQ;
endmodule

// File: rtl/pipe_flow_ctrl.sv
module pipe_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  output logic [AW-1:0] fetchAddr,
  input  logic [IW-1:0] fetchInstr,
  input  logic          branchTaken,
  input  logic [AW-1:0] branchTarget,
  input  logic          pcWrite,
  input  logic [AW-1:0] pcWriteData,
  input  logic          irqReq,
  input  logic [AW-1:0] irqVector,
  output logic          exValid,
  output logic [AW-1:0] exAddr,
  output logic [IW-1:0] exInstr,
  output logic [AW-1:0] exPcRead,
  output logic          irqAck,
  output logic [AW-1:0] retAddr
);
  pipeCtl_t ctl;
  logic     decValid;

  pfc_control u_ctrl (
    .stall       (stall),
    .branchTaken (branchTaken),
    .pcWrite     (pcWrite),
    .irqReq      (irqReq),
    .decValid    (decValid),
    .ctl         (ctl)
  );

  pfc_datapath #(.AW(AW), .IW(IW)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .branchTarget (branchTarget),
    .pcWriteData  (pcWriteData),
    .irqVector    (irqVector),
    .fetchInstr   (fetchInstr),
    .fetchAddr    (fetchAddr),
    .decValid     (decValid),
    .exValid      (exValid),
    .exAddr       (exAddr),
    .exInstr      (exInstr),
    .exPcRead     (exPcRead),
    .irqAck       (irqAck),
    .retAddr      (retAddr)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          branchTaken,
  input logic [AW-1:0] branchTarget,
  input logic          pcWrite,
  input logic [AW-1:0] pcWriteData,
  input logic          irqReq,
  input logic [AW-1:0] irqVector,
  input logic [AW-1:0] fetchAddr,
  input logic          exValid,
  input logic [AW-1:0] exAddr,
  input logic          irqAck,
  input logic [AW-1:0] retAddr
);
  localparam logic [AW-1:0] AMASK = ~(AW'(STEP) - AW'(1));

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!exValid && !irqAck && fetchAddr == '0));

  p_fetch_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchAddr & ~AMASK) == '0);

  p_flush_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !irqReq && (branchTaken || pcWrite)) |=>
      (!exValid && fetchAddr == ((($past(branchTaken)) ? $past(branchTarget)
                                                       : $past(pcWriteData)) & AMASK)));

  p_flush_bubble2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!stall && (branchTaken || pcWrite || irqReq), 2) && $past(!stall)) |-> !exValid);

  p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && exValid && !irqReq && !branchTaken && !pcWrite) |=>
      fetchAddr == $past(fetchAddr) + AW'(STEP));

  p_irq_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && irqReq) |=> (irqAck && !exValid && fetchAddr == ($past(irqVector) & AMASK)));

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irqAck |=> !irqAck || $past(irqReq && !stall));

  p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetchAddr) && $stable(exValid) && $stable(exAddr) && !irqAck));

  p_irq_branch_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && irqReq && branchTaken) |=> retAddr == ($past(branchTarget) & AMASK));
endmodule

bind pipe_flow_ctrl pfc_checker #(.AW(AW), .STEP(IW / 8)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .branchTaken  (branchTaken),
  .branchTarget (branchTarget),
  .pcWrite      (pcWrite),
  .pcWriteData  (pcWriteData),
  .irqReq       (irqReq),
  .irqVector    (irqVector),
  .fetchAddr    (fetchAddr),
  .exValid      (exValid),
  .exAddr       (exAddr),
  .irqAck       (irqAck),
  .retAddr      (retAddr)
);

// File: tb/tb_pipe_flow_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_flow_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 32;
  localparam int MAX_CYC = 4000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall;
  logic [AW-1:0] fetchAddr;
  logic [IW-1:0] fetchInstr;
  logic          branchTaken;
  logic [AW-1:0] branchTarget;
  logic          pcWrite;
  logic [AW-1:0] pcWriteData;
  logic          irqReq;
  logic [AW-1:0] irqVector;
  logic          exValid;
  logic [AW-1:0] exAddr;
  logic [IW-1:0] exInstr;
  logic [AW-1:0] exPcRead;
  logic          irqAck;
  logic [AW-1:0] retAddr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // instruction memory model: word at address a is ~a
  assign fetchInstr = ~fetchAddr;

  pipe_flow_ctrl #(.AW(AW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .fetchAddr(fetchAddr), .fetchInstr(fetchInstr),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .pcWrite(pcWrite), .pcWriteData(pcWriteData),
    .irqReq(irqReq), .irqVector(irqVector),
    .exValid(exValid), .exAddr(exAddr), .exInstr(exInstr),
    .exPcRead(exPcRead), .irqAck(irqAck), .retAddr(retAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [31:0] expPc = 32'h0;
    logic [31:0] savedRet = 32'h0;
    logic [31:0] expTarget = 32'h0;
    logic [31:0] expRet = 32'h0;
    logic [31:0] prevFetch = 32'h0;
    logic [31:0] prevExAddr = 32'h0;
    logic        prevExValid = 1'b0;
    logic        prevStall = 1'b0;
    logic        prevSeq = 1'b0;
    logic        prevRedirect = 1'b0;
    logic        ackExpected = 1'b0;
    int          bubbleLeft = 0;
    int          cyc = 0;
    bit          done = 0;
    bit          br, pw, irq, st;
    logic [31:0] brT, pwD, vec;

    rst_n = 1'b0; stall = 1'b0;
    branchTaken = 1'b0; branchTarget = '0;
    pcWrite = 1'b0; pcWriteData = '0;
    irqReq = 1'b0; irqVector = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(exValid == 1'b0, "R1 exValid in reset", {31'b0, exValid}, 32'h0);
    chk(fetchAddr == 32'h0, "R1 fetchAddr in reset", fetchAddr, 32'h0);
    chk(irqAck == 1'b0, "R1 irqAck in reset", {31'b0, irqAck}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(exValid == 1'b0, "R1 exValid after release", {31'b0, exValid}, 32'h0);
    chk(fetchAddr == 32'h0, "R1 fetchAddr after release", fetchAddr, 32'h0);

    while (!done && cyc < MAX_CYC) begin
      @(posedge clk);
      #1;
      cyc++;

      chk(fetchAddr[1:0] == 2'b00, "R2 fetch alignment", fetchAddr, fetchAddr & 32'hFFFF_FFFC);
      if (prevStall) begin
        chk(fetchAddr == prevFetch, "R7 fetchAddr frozen", fetchAddr, prevFetch);
        chk(exValid == prevExValid, "R7 exValid frozen", {31'b0, exValid}, {31'b0, prevExValid});
        chk(exAddr == prevExAddr, "R7 exAddr frozen", exAddr, prevExAddr);
      end
      if (prevSeq)
        chk(fetchAddr == prevFetch + 32'd4, "R5 sequential step", fetchAddr, prevFetch + 32'd4);
      if (prevRedirect)
        chk(fetchAddr == expTarget, "R4 redirect target", fetchAddr, expTarget);
      if (bubbleLeft > 0)
        chk(exValid == 1'b0, "R4 flush bubble", {31'b0, exValid}, 32'h0);
      if (ackExpected) begin
        chk(irqAck == 1'b1, "R6 irqAck pulse", {31'b0, irqAck}, 32'h1);
        chk(retAddr == expRet, "R6 R8 return address", retAddr, expRet);
      end else begin
        chk(irqAck == 1'b0, "R6 irqAck idle", {31'b0, irqAck}, 32'h0);
      end
      if (exValid) begin
        chk(exPcRead == exAddr + 32'd8, "R3 pc read offset", exPcRead, exAddr + 32'd8);
        chk(exPcRead == fetchAddr, "R3 pc read equals fetch", exPcRead, fetchAddr);
        chk(exInstr == ~exAddr, "R9 execute word", exInstr, ~exAddr);
      end

      // this cycle's inputs: stall pattern and execute-stage requests
      st = (cyc % 7 == 3);
      br = 0; pw = 0; irq = 0;
      brT = '0; pwD = '0; vec = '0;
      if (exValid) begin
        case (exAddr)
          32'h020: begin br = 1; brT = 32'h100; end
          32'h110: begin pw = 1; pwD = 32'h043; end
          32'h050: begin irq = 1; vec = 32'h201; end
          32'h220: begin br = 1; brT = savedRet; end
          32'h070: begin br = 1; brT = 32'h300; irq = 1; vec = 32'h200; end
          default: ;
        endcase
      end
      stall = st;
      branchTaken = br; branchTarget = brT;
      pcWrite = pw; pcWriteData = pwD;
      irqReq = irq; irqVector = vec;

      prevFetch = fetchAddr;
      prevExAddr = exAddr;
      prevExValid = exValid;
      prevStall = st;
      prevSeq = !st && exValid && !(br || pw || irq);
      ackExpected = !st && irq;

      if (bubbleLeft > 0 && !st) bubbleLeft--;
      prevRedirect = 1'b0;
      if (!st && (br || pw || irq)) begin
        prevRedirect = 1'b1;
        bubbleLeft = 2;
        expTarget = (irq ? vec : (br ? brT : pwD)) & 32'hFFFF_FFFC;
      end

      // retirement against the program-order reference
      if (exValid && !st) begin
        chk(exAddr == expPc, "R9 retired address", exAddr, expPc);
        if (irq) begin
          expRet = br ? (brT & 32'hFFFF_FFFC) : expPc + 32'd4;
          savedRet = expRet;
          expPc = vec & 32'hFFFF_FFFC;
        end else if (br) begin
          expPc = brT & 32'hFFFF_FFFC;
        end else if (pw) begin
          expPc = pwD & 32'hFFFF_FFFC;
        end else begin
          expPc = expPc + 32'd4;
        end
        if (exAddr == 32'h320) done = 1;
      end
    end

    checks++;
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog expired actual=%h expected=%h", expPc, 32'h320);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule